// File: doc/BRIEF.md
# Unified Rotating and Static Register File

This block is the local register file of one processing element in a coarse-grained reconfigurable array that runs software-pipelined loops. One physical array of 32-bit registers is divided at a run-time boundary. Logical indices below the boundary form a rotating section. Its logical-to-physical mapping shifts by one slot every initiation interval (II), so a loop body can name a loop-carried value by the same index in every iteration. Older values stay readable at higher indices and are not overwritten. Indices at or above the boundary form a static section. It holds preloaded constants and live-in values, for example wide masks, array base addresses and signed values that do not fit an instruction's short immediate field.

Before a kernel starts, a configuration port sets the boundary and the II and preloads registers. While the kernel enable input is high, the file rotates and ignores configuration traffic. Two combinational read ports and one write port serve the datapath. A read that hits the register being written in the same cycle returns the new data.

Top module: `urf_unified`

## Requirements
- R1: After synchronous active-low reset, every register reads 0, the boundary is 0, the II is 1, and both the rotation base and the II counter are 0.
- R2: A logical index at or above the boundary reaches the physical register with the same index, whatever the rotation state.
- R3: A logical index L below the boundary B reaches physical register (L + base) mod B.
- R4: While run_en is high, the II counter steps 0..II-1. In the cycle it holds II-1, the base moves down by one, modulo B, and the new mapping applies from the next cycle. As a result, a value written at logical L reads at logical L+1 after one rotation.
- R5: While run_en is low, the base and the II counter hold.
- R6: Boundary 0 makes every index static. Boundary equal to DEPTH makes every index rotating. Larger boundary values are clamped to DEPTH.
- R7: A configuration write (cfg_valid high) in a cycle with run_en high changes nothing: no preload, no boundary change and no II change.
- R8: A read of the physical register being written by the write port in the same cycle returns wr_data.
- R9: Writing the boundary resets the base to 0. Writing the II resets the II counter to 0.
- R10: Registers keep all 32 bits of a value.
- R11: A programmed II of 0 acts as II of 1, so the file rotates every enabled cycle.
- R12: Configuration op codes on cfg_op are 0 = preload the physical register cfg_addr with cfg_data, 1 = boundary from the low bits of cfg_data, 2 = II from the low bits of cfg_data, and 3 = no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Kernel running; enables rotation and blocks configuration |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Configuration op code (R12) |
| cfg_addr | input | AW | Physical register for a preload |
| cfg_data | input | WIDTH | Preload data, boundary or II value |
| wr_en | input | 1 | Datapath write enable |
| wr_idx | input | AW | Logical write index |
| wr_data | input | WIDTH | Write data |
| ra_idx | input | AW | Logical index, read port A |
| ra_data | output | WIDTH | Read data, port A |
| rb_idx | input | AW | Logical index, read port B |
| rb_data | output | WIDTH | Read data, port B |

## Verification
The properties assume that rst_n is asserted for at least one clock before any check matters. They also assume that configuration traffic arrives only while run_en is low, so that a boundary or II change never lands in the middle of a rotation. The stimulus loads the boundary, the II and all preloads in idle cycles. It raises run_en only after that, except in the one deliberate test that sends configuration writes while running. In that test the properties expect the file to discard those writes. Expected read values come from the mapping rules in R3 and R4, worked out by hand for each cycle of the vector table.

// File: rtl/urf_pkg.sv
// Shared types for the unified register file.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package urf_pkg;
    typedef enum logic [1:0] {
        CFG_PRELOAD = 2'd0,
        CFG_BOUND   = 2'd1,
        CFG_II      = 2'd2,
        CFG_NOP     = 2'd3
    } cfg_op_e;
endpackage

// File: rtl/urf_cfg.sv
// Configuration registers: boundary, initiation interval and preload strobe.
// Assumes: cfg_data is at least as wide as the boundary and II fields.
module urf_cfg
    import urf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int IIW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_op,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WIDTH-1:0] cfg_data,
    output logic [BW-1:0]    bnd,
    output logic [IIW-1:0]   ii,
    output logic             bnd_wr,
    output logic             ii_wr,
    output logic             pre_en,
    output logic [AW-1:0]    pre_addr,
    output logic [WIDTH-1:0] pre_data
);
    cfg_op_e         op;
    logic            accept;
    logic [BW-1:0]   bnd_req;

    // Decode the op and accept it only while the kernel is idle.
    always_comb begin
        op       = cfg_op_e'(cfg_op);
        accept   = cfg_valid && !run_en;
        bnd_wr   = accept && (op == CFG_BOUND);
        ii_wr    = accept && (op == CFG_II);
        pre_en   = accept && (op == CFG_PRELOAD);
        pre_addr = cfg_addr;
        pre_data = cfg_data;
        bnd_req  = (cfg_data[BW-1:0] > BW'(DEPTH)) ? BW'(DEPTH) : cfg_data[BW-1:0];
    end

    // Hold the boundary and II; reset gives an all-static file and II of 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd <= '0;
            ii  <= IIW'(1);
        end else begin
            if (bnd_wr) bnd <= bnd_req;
            if (ii_wr)  ii  <= cfg_data[IIW-1:0];
        end
    end

    a_r7_cfg_ignored_running: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> ($stable(bnd) && $stable(ii)));
    a_r6_bnd_clamped: assert property (@(posedge clk) disable iff (!rst_n)
        bnd <= BW'(DEPTH));
endmodule

// File: rtl/urf_rotor.sv
// II counter and rotation base for the rotating section.
// Assumes: boundary and II change only while run_en is low.
module urf_rotor #(
    parameter int DEPTH = 16,
    parameter int IIW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic [BW-1:0]  bnd,
    input  logic [IIW-1:0] ii,
    input  logic           bnd_wr,
    input  logic           ii_wr,
    output logic [AW-1:0]  base
);
    logic [IIW-1:0] cnt;
    logic [IIW-1:0] ii_eff;
    logic           wrap;
    logic [AW-1:0]  base_nxt;

    // Effective interval, wrap detect and the next base (one slot down).
    always_comb begin
        ii_eff   = (ii == '0) ? IIW'(1) : ii;
        wrap     = (cnt >= ii_eff - IIW'(1));
        if (bnd == '0)
            base_nxt = '0;
        else if (base == '0)
            base_nxt = AW'(bnd - BW'(1));
        else
            base_nxt = base - AW'(1);
    end

    // Advance the counter while running and rotate on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            base <= '0;
        end else if (bnd_wr) begin
            base <= '0;
        end else if (ii_wr) begin
            cnt <= '0;
        end else if (run_en) begin
            if (wrap) begin
                cnt  <= '0;
                base <= base_nxt;
            end else begin
                cnt <= cnt + IIW'(1);
            end
        end
    end

    a_r3_base_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd != '0) |-> (BW'(base) < bnd));
    a_r4_cnt_below_ii: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ii_eff);
    a_r4_step_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wrap && (bnd > BW'(1))) |=> (base != $past(base)));
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !bnd_wr && !ii_wr) |=> ($stable(base) && $stable(cnt)));
    a_r9_bnd_clears_base: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_wr |=> (base == '0));
endmodule

// File: rtl/urf_map.sv
// Logical-to-physical index translation for one access port.
// Assumes: base < bnd whenever bnd is nonzero.
module urf_map #(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0] lidx,
    input  logic [AW-1:0] base,
    input  logic [BW-1:0] bnd,
    output logic [AW-1:0] pidx
);
    logic [BW:0] sum;

    // Rotating indices wrap inside the section; static ones pass through.
    always_comb begin
        sum = (BW+1)'(lidx) + (BW+1)'(base);
        if (BW'(lidx) < bnd)
            pidx = (sum >= (BW+1)'(bnd)) ? AW'(sum - (BW+1)'(bnd)) : AW'(sum);
        else
            pidx = lidx;
    end
endmodule

// File: rtl/urf_store.sv
// Register array with one write port, a preload port and NRD bypassed reads.
// Assumes: when preload and write hit one register, the write wins.
module urf_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wp,
    input  logic [WIDTH-1:0]          wdata,
    input  logic                      pre_en,
    input  logic [AW-1:0]             pa,
    input  logic [WIDTH-1:0]          pdata,
    input  logic [NRD-1:0][AW-1:0]    rp,
    output logic [NRD-1:0][WIDTH-1:0] rd
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Clear on reset, then apply preload and datapath write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (pre_en) mem[pa] <= pdata;
            if (wr_en)  mem[wp] <= wdata;
        end
    end

    // One write-first read path per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        always_comb
            rd[g] = (wr_en && (wp == rp[g])) ? wdata : mem[rp[g]];
    end

    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wp)] == $past(wdata)));
endmodule

// File: rtl/urf_unified.sv
// Top of the unified register file: config, rotor, index maps, storage.
// Assumes: WIDTH >= field widths of boundary and II in cfg_data.
module urf_unified #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int IIW   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int BW   = $clog2(DEPTH + 1),
    localparam int NRD  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cfg_valid,
    input  logic [1:0]       cfg_op,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [WIDTH-1:0] cfg_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    ra_idx,
    output logic [WIDTH-1:0] ra_data,
    input  logic [AW-1:0]    rb_idx,
    output logic [WIDTH-1:0] rb_data
);
    logic [BW-1:0]             bnd;
    logic [IIW-1:0]            ii;
    logic                      bnd_wr, ii_wr, pre_en;
    logic [AW-1:0]             pre_addr;
    logic [WIDTH-1:0]          pre_data;
    logic [AW-1:0]             base;
    logic [NRD:0][AW-1:0]      lidx;
    logic [NRD:0][AW-1:0]      pidx;
    logic [NRD-1:0][WIDTH-1:0] rd;

    urf_cfg #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IIW(IIW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .cfg_valid(cfg_valid), .cfg_op(cfg_op), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .bnd(bnd), .ii(ii), .bnd_wr(bnd_wr),
        .ii_wr(ii_wr), .pre_en(pre_en), .pre_addr(pre_addr),
        .pre_data(pre_data)
    );

    urf_rotor #(.DEPTH(DEPTH), .IIW(IIW)) u_rotor (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .bnd(bnd), .ii(ii),
        .bnd_wr(bnd_wr), .ii_wr(ii_wr), .base(base)
    );

    // Port order for translation: write port first, then the read ports.
    always_comb begin
        lidx[0] = wr_idx;
        lidx[1] = ra_idx;
        lidx[2] = rb_idx;
    end

    for (genvar g = 0; g <= NRD; g++) begin : g_map
        urf_map #(.DEPTH(DEPTH)) u_map (
            .lidx(lidx[g]), .base(base), .bnd(bnd), .pidx(pidx[g])
        );
    end

    urf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NRD(NRD)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wp(pidx[0]),
        .wdata(wr_data), .pre_en(pre_en), .pa(pre_addr), .pdata(pre_data),
        .rp(pidx[NRD:1]), .rd(rd)
    );

    // Drive the read data outputs.
    always_comb begin
        ra_data = rd[0];
        rb_data = rd[1];
    end

    a_r2_static_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (BW'(ra_idx) >= bnd) |-> (pidx[1] == ra_idx));
    a_r3_rot_in_section: assert property (@(posedge clk) disable iff (!rst_n)
        (BW'(rb_idx) < bnd) |-> (BW'(pidx[2]) < bnd));
endmodule

// File: tb/sim_urf_unified.sv
module sim_urf_unified;
    localparam int DEPTH = 16;
    localparam int WIDTH = 32;
    localparam int AW    = 4;

    typedef struct packed {
        logic        we;
        logic [3:0]  wi;
        logic [31:0] wd;
        logic [3:0]  a;
        logic [3:0]  b;
        logic [31:0] ea;
        logic [31:0] eb;
    } vec_t;

    // Boundary 4, II 2, run_en high every row; base per row 0,0,3,3,2,2,1,1.
    localparam vec_t TBL [8] = '{
        '{1'b1, 4'd0, 32'h100, 4'd0,  4'd5, 32'h100, 32'hDEADBEEF},
        '{1'b0, 4'd0, 32'h0,   4'd0,  4'd1, 32'h100, 32'hA1},
        '{1'b1, 4'd0, 32'h200, 4'd1,  4'd3, 32'h100, 32'hA2},
        '{1'b0, 4'd0, 32'h0,   4'd1,  4'd0, 32'h100, 32'h200},
        '{1'b1, 4'd0, 32'h300, 4'd2,  4'd1, 32'h100, 32'h200},
        '{1'b0, 4'd0, 32'h0,   4'd0,  4'd15, 32'h300, 32'h80000001},
        '{1'b0, 4'd0, 32'h0,   4'd3,  4'd2, 32'h100, 32'h200},
        '{1'b0, 4'd0, 32'h0,   4'd5,  4'd0, 32'hDEADBEEF, 32'hA1}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             run_en = 1'b0;
    logic             cfg_valid = 1'b0;
    logic [1:0]       cfg_op = 2'd3;
    logic [AW-1:0]    cfg_addr = '0;
    logic [WIDTH-1:0] cfg_data = '0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_idx = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [AW-1:0]    ra_idx = '0;
    logic [AW-1:0]    rb_idx = '0;
    logic [WIDTH-1:0] ra_data, rb_data;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    urf_unified #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_valid(cfg_valid),
        .cfg_op(cfg_op), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One idle configuration write (cfg_op codes per R12).
    task automatic cfg_wr(input logic [1:0] op, input logic [3:0] addr, input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = op; cfg_addr = addr; cfg_data = d;
        @(negedge clk);
        cfg_valid = 1'b0; cfg_op = 2'd3;
    endtask

    task automatic rd2(input logic [3:0] a, input logic [3:0] b);
        ra_idx = a; rb_idx = b; #2;
    endtask

    initial begin
        #(20 * 100000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: storage cleared after reset
        rd2(4'd0, 4'd15);
        chk("R1 L0 after reset", ra_data, 32'h0);
        chk("R1 L15 after reset", rb_data, 32'h0);

        cfg_wr(2'd1, 4'd0, 32'd4);
        cfg_wr(2'd2, 4'd0, 32'd2);
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 5)       cfg_wr(2'd0, 4'(i), 32'hDEADBEEF);
            else if (i == 15) cfg_wr(2'd0, 4'(i), 32'h80000001);
            else              cfg_wr(2'd0, 4'(i), 32'hA0 + 32'(i));
        end

        // R2 R3 R4 R8 R10: rotation walk
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            run_en = 1'b1;
            wr_en = TBL[k].we; wr_idx = TBL[k].wi; wr_data = TBL[k].wd;
            rd2(TBL[k].a, TBL[k].b);
            chk($sformatf("R3 R4 R8 row %0d port A", k), ra_data, TBL[k].ea);
            chk($sformatf("R2 R10 row %0d port B", k), rb_data, TBL[k].eb);
        end
        @(negedge clk);
        run_en = 1'b0; wr_en = 1'b0;
        // R5: held while idle
        repeat (5) @(negedge clk);
        rd2(4'd0, 4'd1);
        chk("R5 L0 held", ra_data, 32'h100);
        chk("R5 L1 held", rb_data, 32'hA1);

        // R7: configuration ignored while running
        run_en = 1'b1;
        cfg_valid = 1'b1; cfg_op = 2'd0; cfg_addr = 4'd6; cfg_data = 32'h1234;
        @(negedge clk);
        cfg_op = 2'd1; cfg_data = 32'd0;
        @(negedge clk);
        run_en = 1'b0; cfg_valid = 1'b0; cfg_op = 2'd3;
        rd2(4'd6, 4'd1);
        chk("R7 preload ignored", ra_data, 32'hA6);
        chk("R7 boundary ignored", rb_data, 32'h100);

        // R9 R6: full rotation after boundary = DEPTH
        cfg_wr(2'd1, 4'd0, 32'd16);
        rd2(4'd1, 4'd2);
        chk("R9 base cleared", ra_data, 32'hA1);
        cfg_wr(2'd2, 4'd0, 32'd0);
        run_en = 1'b1; wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'h555;
        @(negedge clk);
        run_en = 1'b0; wr_en = 1'b0;
        rd2(4'd1, 4'd15);
        chk("R6 R11 all rotating L1", ra_data, 32'h555);
        chk("R6 R11 all rotating L15", rb_data, 32'hAE);

        // R6: boundary 0 gives all static
        cfg_wr(2'd1, 4'd0, 32'd0);
        run_en = 1'b1;
        repeat (3) @(negedge clk);
        run_en = 1'b0;
        rd2(4'd0, 4'd15);
        chk("R6 all static L0", ra_data, 32'h555);
        chk("R6 all static L15", rb_data, 32'h80000001);

        // R12: op 3 changes nothing
        cfg_wr(2'd3, 4'd0, 32'h77);
        rd2(4'd0, 4'd1);
        chk("R12 nop L0", ra_data, 32'h555);
        chk("R12 nop L1", rb_data, 32'hA1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule